// File: doc/BRIEF.md
# Parallel ADC Capture and Packing Port

This block takes samples from an external parallel converter whose data bus is timed by its own acquisition clock. Each sample is taken on the chosen edge of that clock and carried into the system clock domain. The system domain watches a two-flop synchronized copy of the acquisition clock for the selected edge. On that edge it reads a register that the acquisition clock loaded at the same edge. The port then applies a per-bit mask to the sample, skips it if the converter's hold line was high, and packs it into a 32-bit word. A word can hold either one 20-bit sample or two 16-bit samples.

Finished words go into an eight-entry FIFO. A DMA-style consumer empties the FIFO through a ready/valid read port. Each finished word also produces a one-cycle strobe, which can serve as an interrupt source. A sticky flag records any word lost because the FIFO was full.

Configuration comes in as static inputs: the enable, the edge select, the packing mode and the mask. The acquisition clock must run at no more than a quarter of the system clock.

Top module: `pcap_port`

## Requirements
- R1: After reset, rd_valid, overflow and word_strobe are all 0.
- R2: Each bit of the 20-bit sample is ANDed with the matching bit of cfg_mask, so a 0 in cfg_mask forces that bit to 0 in the packed word.
- R3: A sample taken while acq_hold is 1 produces no word, no strobe and no change to the packing phase.
- R4: With cfg_fall_edge = 0 the data and hold present at the rising acquisition edge are used. With cfg_fall_edge = 1 the data and hold present at the falling edge are used.
- R5: With cfg_pack_dual = 0, each accepted sample becomes one word, with the masked sample in bits 31:12 and zeros in bits 11:0.
- R6: With cfg_pack_dual = 1, the first accepted sample's low 16 masked bits go to bits 15:0 and the second sample's go to bits 31:16. The word is pushed only after the second sample arrives.
- R7: The FIFO holds up to 8 words and returns them in the order they were packed. rd_data shows the oldest word while rd_valid is 1, and a cycle with rd_valid and rd_ready both 1 removes it.
- R8: word_strobe is high for exactly one system cycle for each completed word, including a word that is then dropped.
- R9: While cfg_enable is 0, no sample is taken, the packing phase returns to the first slot and the FIFO is emptied.
- R10: A word completed while the FIFO is full and not being read is discarded, and overflow becomes 1. It stays 1 until ovf_clear is pulsed; if both happen in the same cycle, the set wins.
- R11: Capture stays correct with an acquisition clock whose period is four system clock cycles, with each level lasting at least two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_clk | input | 1 | Acquisition clock from the converter |
| acq_data | input | 20 | Parallel sample bus |
| acq_hold | input | 1 | Marks the current sample as not to be captured |
| cfg_enable | input | 1 | Capture enable; 0 flushes the FIFO and packer |
| cfg_fall_edge | input | 1 | 0 = rising acquisition edge, 1 = falling |
| cfg_pack_dual | input | 1 | 0 = one 20-bit sample per word, 1 = two 16-bit samples |
| cfg_mask | input | 20 | Per-bit pass mask, 1 passes the bit |
| ovf_clear | input | 1 | Pulse that clears the overflow flag |
| rd_ready | input | 1 | Consumer accepts the word at the head |
| rd_valid | output | 1 | FIFO not empty |
| rd_data | output | 32 | Oldest packed word |
| word_strobe | output | 1 | One-cycle pulse per completed word |
| overflow | output | 1 | Sticky flag for a lost word |

## Verification
A selected acquisition edge passes through two synchronizer flops and one edge-compare stage. The packer register then raises word_strobe on the third system edge after the acquisition edge, and the FIFO count, and so rd_valid, changes on the fourth. The bench drives each acquisition period as a fixed sequence of system cycles. That sequence always ends at least four cycles after the last edge it used. The behavioural model is updated, and the strobe count, overflow and rd_valid are compared, only at the end of each period. Words are compared on the falling clock edge during a drain, one per accepted read.

// File: rtl/pcap_pkg.sv
package pcap_pkg;
    localparam int SAMPLE_W = 20;
    localparam int HALF_W   = 16;
    localparam int WORD_W   = 32;
    localparam int PAD_W    = WORD_W - SAMPLE_W;

    typedef enum logic {
        PACK_SINGLE20 = 1'b0,
        PACK_DUAL16   = 1'b1
    } pack_mode_e;

    typedef struct packed {
        logic [SAMPLE_W-1:0] data;
        logic                hold;
    } acq_sample_t;

    function automatic logic [WORD_W-1:0] align_single(input logic [SAMPLE_W-1:0] s);
        return {s, {PAD_W{1'b0}}};
    endfunction

    function automatic logic [WORD_W-1:0] join_halves(input logic [HALF_W-1:0] hi,
                                                      input logic [HALF_W-1:0] lo);
        return {hi, lo};
    endfunction
endpackage

// File: rtl/pcap_capture.sv
module pcap_capture
    import pcap_pkg::*;
(
    input  logic                acq_clk,
    input  logic [SAMPLE_W-1:0] acq_data,
    input  logic                acq_hold,
    output acq_sample_t         rise_q,
    output acq_sample_t         fall_q
);
    // Both edges are always latched; the system domain chooses which to read.
    always_ff @(posedge acq_clk) begin
        rise_q.data <= acq_data;
        rise_q.hold <= acq_hold;
    end

    always_ff @(negedge acq_clk) begin
        fall_q.data <= acq_data;
        fall_q.hold <= acq_hold;
    end
endmodule

// File: rtl/pcap_sync.sv
module pcap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic acq_clk,
    input  logic fall_sel,
    output logic edge_ev
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], acq_clk};
            last  <= chain[STAGES-1];
        end
    end

    assign edge_ev = fall_sel ? (last & ~chain[STAGES-1])
                              : (chain[STAGES-1] & ~last);

    // R11: with a clock at most a quarter of clk, each level lasts two cycles or more
    a_r11_acq_rate: assert property (@(posedge clk) disable iff (rst)
        (chain[STAGES-1] != last) |=> (chain[STAGES-1] == last));
endmodule

// File: rtl/pcap_packer.sv
module pcap_packer
    import pcap_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  pack_mode_e          mode,
    input  logic [SAMPLE_W-1:0] mask,
    input  logic                edge_ev,
    input  acq_sample_t         sample,
    output logic                word_done,
    output logic [WORD_W-1:0]   word
);
    logic [SAMPLE_W-1:0] masked;
    logic [HALF_W-1:0]   lo_half;
    logic                phase;
    logic                take;

    assign masked = sample.data & mask;
    assign take   = edge_ev & ~sample.hold;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            phase     <= 1'b0;
            lo_half   <= '0;
            word_done <= 1'b0;
            word      <= '0;
        end else begin
            word_done <= 1'b0;
            if (take) begin
                if (mode == PACK_SINGLE20) begin
                    phase     <= 1'b0;
                    word      <= align_single(masked);
                    word_done <= 1'b1;
                end else if (!phase) begin
                    lo_half <= masked[HALF_W-1:0];
                    phase   <= 1'b1;
                end else begin
                    word      <= join_halves(masked[HALF_W-1:0], lo_half);
                    phase     <= 1'b0;
                    word_done <= 1'b1;
                end
            end
        end
    end

    // R3: a held sample leaves the phase alone and completes nothing
    a_r3_hold_freeze: assert property (@(posedge clk) disable iff (rst)
        (enable && edge_ev && sample.hold) |=> (phase == $past(phase) && !word_done));

    // R6: in dual mode a word completes only from the second slot
    a_r6_pair_only: assert property (@(posedge clk) disable iff (rst)
        (enable && mode == PACK_DUAL16 && edge_ev && !sample.hold && !phase) |=> !word_done);

    // R5: single mode words carry zero padding below the sample
    a_r5_pad_zero: assert property (@(posedge clk) disable iff (rst)
        (enable && mode == PACK_SINGLE20 && take) |=> (word[PAD_W-1:0] == '0));
endmodule

// File: rtl/pcap_fifo.sv
module pcap_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rd_ready,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_data,
    output logic             drop
);
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic [WIDTH-1:0]  mem [DEPTH];
    logic [ADDR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0]  count;
    logic              pop, accept, full;

    assign full     = (count == CNT_W'(DEPTH));
    assign rd_valid = (count != '0);
    assign rd_data  = mem[rptr];
    assign pop      = rd_valid & rd_ready;
    assign accept   = push & (~full | pop);
    assign drop     = push & ~accept;

    function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] p);
        return (p == ADDR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (accept && !flush) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (accept) wptr <= bump(wptr);
            if (pop)    rptr <= bump(rptr);
            case ({accept, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R7: occupancy never exceeds the depth
    a_r7_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R10: a dropped word never changes the occupancy upward
    a_r10_drop_holds: assert property (@(posedge clk) disable iff (rst)
        (drop && !flush) |=> (count == CNT_W'(DEPTH)));
endmodule

// File: rtl/pcap_port.sv
module pcap_port
    import pcap_pkg::*;
#(
    parameter int FIFO_DEPTH  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                acq_clk,
    input  logic [SAMPLE_W-1:0] acq_data,
    input  logic                acq_hold,
    input  logic                cfg_enable,
    input  logic                cfg_fall_edge,
    input  logic                cfg_pack_dual,
    input  logic [SAMPLE_W-1:0] cfg_mask,
    input  logic                ovf_clear,
    input  logic                rd_ready,
    output logic                rd_valid,
    output logic [WORD_W-1:0]   rd_data,
    output logic                word_strobe,
    output logic                overflow
);
    acq_sample_t       rise_q, fall_q, chosen;
    logic              edge_ev, word_done, drop;
    logic [WORD_W-1:0] word;
    pack_mode_e        mode;

    assign mode   = cfg_pack_dual ? PACK_DUAL16 : PACK_SINGLE20;
    assign chosen = cfg_fall_edge ? fall_q : rise_q;

    pcap_capture u_cap (
        .acq_clk  (acq_clk),
        .acq_data (acq_data),
        .acq_hold (acq_hold),
        .rise_q   (rise_q),
        .fall_q   (fall_q)
    );

    pcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .acq_clk  (acq_clk),
        .fall_sel (cfg_fall_edge),
        .edge_ev  (edge_ev)
    );

    pcap_packer u_pack (
        .clk       (clk),
        .rst       (rst),
        .enable    (cfg_enable),
        .mode      (mode),
        .mask      (cfg_mask),
        .edge_ev   (edge_ev),
        .sample    (chosen),
        .word_done (word_done),
        .word      (word)
    );

    pcap_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(WORD_W)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .flush    (~cfg_enable),
        .push     (word_done),
        .wdata    (word),
        .rd_ready (rd_ready),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .drop     (drop)
    );

    assign word_strobe = word_done;

    always_ff @(posedge clk) begin
        if (rst)            overflow <= 1'b0;
        else if (drop)      overflow <= 1'b1;
        else if (ovf_clear) overflow <= 1'b0;
    end

    // R10: the flag stays set until a clear pulse
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        (overflow && !ovf_clear) |=> overflow);

    // R8: the strobe is a single-cycle pulse
    a_r8_strobe_pulse: assert property (@(posedge clk) disable iff (rst)
        word_strobe |=> !word_strobe);

    // R9: a disabled port shows an empty FIFO on the next cycle
    a_r9_flush: assert property (@(posedge clk) disable iff (rst)
        !cfg_enable |=> !rd_valid);
endmodule

// File: tb/pcap_port_test.sv
module pcap_port_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acq_clk = 1'b0;
    logic [19:0] acq_data = '0;
    logic        acq_hold = 1'b0;
    logic        cfg_enable = 1'b0;
    logic        cfg_fall_edge = 1'b0;
    logic        cfg_pack_dual = 1'b0;
    logic [19:0] cfg_mask = 20'hFFFFF;
    logic        ovf_clear = 1'b0;
    logic        rd_ready = 1'b0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        word_strobe;
    logic        overflow;

    int checks = 0;
    int failures = 0;
    int strobe_seen = 0;
    bit done = 1'b0;

    logic [31:0] q[$];
    bit          m_phase = 1'b0;
    logic [15:0] m_lo = '0;
    int          m_strobes = 0;
    bit          m_ovf = 1'b0;

    pcap_port uut (
        .clk(clk), .rst(rst), .acq_clk(acq_clk), .acq_data(acq_data),
        .acq_hold(acq_hold), .cfg_enable(cfg_enable), .cfg_fall_edge(cfg_fall_edge),
        .cfg_pack_dual(cfg_pack_dual), .cfg_mask(cfg_mask), .ovf_clear(ovf_clear),
        .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .word_strobe(word_strobe), .overflow(overflow)
    );

    always #4 clk = ~clk;

    always @(negedge clk) if (!rst && word_strobe) strobe_seen++;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_take(input logic [19:0] d, input bit h);
        logic [19:0] m;
        logic [31:0] w;
        bit          made;
        if (!cfg_enable || h) return;
        m = d & cfg_mask;
        made = 1'b0;
        if (!cfg_pack_dual) begin
            w = {m, 12'h000}; made = 1'b1; m_phase = 1'b0;
        end else if (!m_phase) begin
            m_lo = m[15:0]; m_phase = 1'b1;
        end else begin
            w = {m[15:0], m_lo}; made = 1'b1; m_phase = 1'b0;
        end
        if (made) begin
            m_strobes++;
            if (q.size() < 8) q.push_back(w);
            else m_ovf = 1'b1;
        end
    endtask

    task automatic compare_state(input string req);
        chk(strobe_seen == m_strobes, {req, " strobe count"}, strobe_seen, m_strobes);
        chk(overflow == m_ovf, {req, " overflow"}, overflow, m_ovf);
        chk(rd_valid == (q.size() != 0), {req, " rd_valid"}, rd_valid, q.size() != 0);
    endtask

    // One acquisition period of 12 system cycles; different values may sit at each edge.
    task automatic acq_period(input logic [19:0] dr, input bit hr,
                              input logic [19:0] df, input bit hf, input string req);
        acq_data = dr; acq_hold = hr;
        cycles(2);
        acq_clk = 1'b1;
        cycles(2);
        acq_data = df; acq_hold = hf;
        cycles(2);
        acq_clk = 1'b0;
        cycles(6);
        if (cfg_fall_edge) model_take(df, hf);
        else model_take(dr, hr);
        compare_state(req);
    endtask

    task automatic sample(input logic [19:0] d, input bit h, input string req);
        acq_period(d, h, d, h, req);
    endtask

    task automatic drain(input string req);
        int guard;
        guard = 0;
        rd_ready = 1'b1;
        while (rd_valid && guard < 20) begin
            if (q.size() == 0) begin
                chk(1'b0, {req, " extra word"}, rd_data, 32'h0);
            end else begin
                chk(rd_data == q[0], {req, " word"}, rd_data, q[0]);
                void'(q.pop_front());
            end
            guard++;
            @(negedge clk);
        end
        rd_ready = 1'b0;
        chk(q.size() == 0, {req, " words left in model"}, q.size(), 0);
    endtask

    task automatic set_enable(input bit en);
        cfg_enable = en;
        cycles(2);
        if (!en) begin
            q.delete();
            m_phase = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cycles(3);
        rst = 1'b0;
        cycles(1);
        // R1: reset state
        chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
        chk(overflow == 1'b0, "R1 overflow", overflow, 0);
        chk(word_strobe == 1'b0, "R1 word_strobe", word_strobe, 0);

        // R5 R7 R8: single mode, rising edge
        set_enable(1'b1);
        sample(20'hABCDE, 1'b0, "R5");
        sample(20'h12345, 1'b0, "R8");
        sample(20'hFFFFF, 1'b0, "R7");
        drain("R5");

        // R2: per-bit mask
        cfg_mask = 20'hF0F3C;
        sample(20'hFFFFF, 1'b0, "R2");
        sample(20'h5A5A5, 1'b0, "R2");
        drain("R2");
        cfg_mask = 20'hFFFFF;

        // R3: held sample between two good ones
        sample(20'h00011, 1'b0, "R3");
        sample(20'h00022, 1'b1, "R3");
        sample(20'h00033, 1'b0, "R3");
        drain("R3");

        // R4: distinct data at each edge, rising then falling
        acq_period(20'h11111, 1'b0, 20'h22222, 1'b0, "R4");
        acq_period(20'h33333, 1'b1, 20'h44444, 1'b0, "R4");
        drain("R4");
        cfg_fall_edge = 1'b1;
        cycles(4);
        acq_period(20'h55555, 1'b0, 20'h66666, 1'b0, "R4");
        acq_period(20'h77777, 1'b0, 20'h88888, 1'b1, "R4");
        drain("R4");
        cfg_fall_edge = 1'b0;
        cycles(4);

        // R6: dual mode, hold in the middle of a pair
        cfg_pack_dual = 1'b1;
        sample(20'hA1234, 1'b0, "R6");
        chk(rd_valid == 1'b0, "R6 no word after first half", rd_valid, 0);
        sample(20'hB5678, 1'b1, "R6");
        sample(20'hC9ABC, 1'b0, "R6");
        sample(20'h0DEF0, 1'b0, "R6");
        sample(20'h1CAFE, 1'b0, "R6");
        drain("R6");

        // R9: disable resets the pair phase and flushes the FIFO
        sample(20'h0AAAA, 1'b0, "R9");
        cfg_pack_dual = 1'b0;
        sample(20'h0BBBB, 1'b0, "R9");
        cfg_pack_dual = 1'b1;
        sample(20'h0CCCC, 1'b0, "R9");
        set_enable(1'b0);
        chk(rd_valid == 1'b0, "R9 flushed", rd_valid, 0);
        sample(20'h0DDDD, 1'b0, "R9");
        set_enable(1'b1);
        sample(20'h01111, 1'b0, "R9");
        sample(20'h02222, 1'b0, "R9");
        drain("R9");
        cfg_pack_dual = 1'b0;

        // R10: overflow with ten words and no reads
        for (int i = 0; i < 10; i++) sample(20'h40000 + 20'(i), 1'b0, "R10");
        chk(overflow == 1'b1, "R10 flag set", overflow, 1);
        drain("R10");
        chk(overflow == 1'b1, "R10 flag sticky", overflow, 1);
        ovf_clear = 1'b1;
        cycles(1);
        ovf_clear = 1'b0;
        m_ovf = 1'b0;
        cycles(1);
        chk(overflow == 1'b0, "R10 flag cleared", overflow, 0);

        // R11: fastest allowed acquisition clock, four system cycles per period
        for (int i = 0; i < 4; i++) begin
            acq_data = 20'h9000F ^ 20'(i * 37); acq_hold = 1'b0;
            cycles(1);
            acq_clk = 1'b1;
            cycles(2);
            acq_clk = 1'b0;
            cycles(1);
            model_take(20'h9000F ^ 20'(i * 37), 1'b0);
        end
        cycles(6);
        compare_state("R11");
        drain("R11");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule